// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggers

This block is one 16-pin general-purpose I/O bank controlled through a small 16-bit register port. Software sets each pin's direction, output value and alternate-function selection. The bank exports these settings as three vectors for the pad logic. The raw pin inputs are resynchronized. Software can read them back as a status word.

Any pin can raise an interrupt. A trigger-type bit picks edge or level detection for the pin. In edge mode an edge-polarity bit picks rising or falling. In level mode a level-polarity bit picks active-high or active-low. Detected events collect in a pending register. Software can overwrite that register freely, so a write of zero clears all pending bits at once. The summary interrupt output is high while a pending bit is set whose mask bit is zero.

A chip can place several of these banks side by side at a fixed address stride. Software can emulate dual-edge detection by flipping the edge-polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the registers at these addresses read 0: direction, output, alternate, trigger-type, edge-polarity, level-polarity and pending. The mask reads 16'hFFFF, and `irq_o` is low.
- R2: Register addresses are 0 direction, 1 output, 2 alternate, 4 mask, 5 trigger-type, 6 edge-polarity and 7 level-polarity. Each reads back what was written. Bit i of direction drives `oe_o[i]`, where 1 means output. Output drives `out_o`, and alternate drives `alt_o`.
- R3: Address 3 reads the pin levels after a two-flop synchronizer. A change on `pin_i` before clock edge k is readable after edge k+1 and not after edge k.
- R4: With trigger-type=1 and edge-polarity=1, a rising edge on a pin sets its pending bit. A pin change before edge k is readable in pending after edge k+2. A pin that stays high does not set the bit again.
- R5: With trigger-type=1 and edge-polarity=0, only a falling edge sets the pending bit. A rising edge leaves it clear.
- R6: With trigger-type=0, the pending bit is set on every cycle that the synchronized level equals level-polarity, where 1 means active-high and 0 means active-low.
- R7: A level-triggered pin whose level is still active keeps its pending bit set across a software write of zero.
- R8: A write to address 8 (pending) loads the written value into the pending register.
- R9: When a hardware event and a software write to pending fall on the same edge, the event's bit ends up set.
- R10: `irq_o` equals the OR over all pins of pending AND NOT mask. A masked pin still records its pending bit.
- R11: Edge-polarity has no effect in level mode, and level-polarity has no effect in edge mode.
- R12: Writes to address 3 are ignored. Reads of unused addresses (9 to 15) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| pin_i | input | 16 | Raw pin inputs |
| oe_o | output | 16 | Per-pin output enable |
| out_o | output | 16 | Per-pin output value |
| alt_o | output | 16 | Per-pin alternate-function select |
| irq_o | output | 1 | Summary interrupt |

## Verification
A register write takes effect on the edge where the strobe is sampled, and reads are combinational, so control outputs and read-back are checked in the low phase just after that edge. A pin change made before edge k shows up in the status word after edge k+1, and in pending and `irq_o` after edge k+2. The bench samples at exactly those negedges and also checks one edge earlier, so a lost or extra synchronizer stage is caught. The same-edge race between an event and a clear is set up by issuing the write so that it lands on the edge where the detector is active.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NPIN = 16;
  localparam int unsigned AW   = 4;

  typedef logic [NPIN-1:0] pinvec_t;

  typedef enum logic [AW-1:0] {
    A_DIR  = 4'd0,
    A_OUT  = 4'd1,
    A_ALT  = 4'd2,
    A_PIN  = 4'd3,
    A_MASK = 4'd4,
    A_TYPE = 4'd5,
    A_EDGE = 4'd6,
    A_LVL  = 4'd7,
    A_PEND = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] type_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] hit_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise = sync_i[i] & ~prev_i[i];
    assign fall = ~sync_i[i] & prev_i[i];
    assign hit_o[i] = type_i[i] ? (edge_i[i] ? rise : fall)
                                : (sync_i[i] == lvl_i[i]);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  pinvec_t       wdata_i,
  input  pinvec_t       sync_i,
  input  pinvec_t       hit_i,
  output pinvec_t       rdata_o,
  output pinvec_t       dir_o,
  output pinvec_t       out_o,
  output pinvec_t       alt_o,
  output pinvec_t       mask_o,
  output pinvec_t       type_o,
  output pinvec_t       edge_o,
  output pinvec_t       lvl_o,
  output pinvec_t       pend_o
);
  pinvec_t dir_q, out_q, alt_q, mask_q, type_q, edge_q, lvl_q, pend_q, pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      alt_q  <= '0;
      mask_q <= '1;
      type_q <= '0;
      edge_q <= '0;
      lvl_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_DIR:   dir_q  <= wdata_i;
        A_OUT:   out_q  <= wdata_i;
        A_ALT:   alt_q  <= wdata_i;
        A_MASK:  mask_q <= wdata_i;
        A_TYPE:  type_q <= wdata_i;
        A_EDGE:  edge_q <= wdata_i;
        A_LVL:   lvl_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // hardware set has priority over a software load
  always_comb begin
    pend_d = pend_q;
    if (we_i && addr_i == A_PEND) pend_d = wdata_i;
    pend_d = pend_d | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;

  always_comb begin
    case (addr_i)
      A_DIR:   rdata_o = dir_q;
      A_OUT:   rdata_o = out_q;
      A_ALT:   rdata_o = alt_q;
      A_PIN:   rdata_o = sync_i;
      A_MASK:  rdata_o = mask_q;
      A_TYPE:  rdata_o = type_q;
      A_EDGE:  rdata_o = edge_q;
      A_LVL:   rdata_o = lvl_q;
      A_PEND:  rdata_o = pend_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign alt_o  = alt_q;
  assign mask_o = mask_q;
  assign type_o = type_q;
  assign edge_o = edge_q;
  assign lvl_o  = lvl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  input  logic [15:0]   pin_i,
  output logic [15:0]   oe_o,
  output logic [15:0]   out_o,
  output logic [15:0]   alt_o,
  output logic          irq_o
);
  pinvec_t sync_w, prev_q, hit_w;
  pinvec_t mask_w, type_w, edge_w, lvl_w, pend_w;

  gpio_bank_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  // reference sample for edge detection
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_w;

  gpio_bank_trig #(.W(NPIN)) u_trig (
    .sync_i(sync_w),
    .prev_i(prev_q),
    .type_i(type_w),
    .edge_i(edge_w),
    .lvl_i (lvl_w),
    .hit_o (hit_w)
  );

  gpio_bank_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .sync_i (sync_w),
    .hit_i  (hit_w),
    .rdata_o(reg_rdata_o),
    .dir_o  (oe_o),
    .out_o  (out_o),
    .alt_o  (alt_o),
    .mask_o (mask_w),
    .type_o (type_w),
    .edge_o (edge_w),
    .lvl_o  (lvl_w),
    .pend_o (pend_w)
  );

  assign irq_o = |(pend_w & ~mask_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [15:0]   wdata_i,
  input logic [15:0]   pin_i,
  input logic [15:0]   oe_i,
  input logic          irq_i,
  input logic [15:0]   sync_i,
  input logic [15:0]   prev_i,
  input logic [15:0]   hit_i,
  input logic [15:0]   type_i,
  input logic [15:0]   edge_i,
  input logic [15:0]   lvl_i,
  input logic [15:0]   mask_i,
  input logic [15:0]   pend_i
);
  logic [1:0] cyc_q;
  logic       wr_pend;
  logic [15:0] rise_v, fall_v, lvl_v, wr_v;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;

  assign wr_pend = we_i && (addr_i == A_PEND);
  assign wr_v    = wr_pend ? wdata_i : 16'h0;
  assign rise_v  = type_i & edge_i & sync_i & ~prev_i;
  assign fall_v  = type_i & ~edge_i & ~sync_i & prev_i;
  assign lvl_v   = ~type_i & ~(sync_i ^ lvl_i);

  // R3
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (sync_i == $past(pin_i, 2)));

  // R4
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_v) |=> ((pend_i & $past(rise_v)) == $past(rise_v)));

  // R5
  fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_v) |=> ((pend_i & $past(fall_v)) == $past(fall_v)));

  // R6
  lvl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_v) |=> ((pend_i & $past(lvl_v)) == $past(lvl_v)));

  // R8
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~$past(pend_i) & ~$past(hit_i) & ~$past(wr_v)) == 16'h0));

  // R10
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_i);

  // R2
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_DIR) |=> $stable(oe_i));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (reg_we_i),
  .addr_i (reg_addr_i),
  .wdata_i(reg_wdata_i),
  .pin_i  (pin_i),
  .oe_i   (oe_o),
  .irq_i  (irq_o),
  .sync_i (sync_w),
  .prev_i (prev_q),
  .hit_i  (hit_w),
  .type_i (type_w),
  .edge_i (edge_w),
  .lvl_i  (lvl_w),
  .mask_i (mask_w),
  .pend_i (pend_w)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/100ps
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata, pin, oe, outv, alt;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  localparam logic [3:0] RA_DIR = 4'd0, RA_OUT = 4'd1, RA_ALT = 4'd2, RA_PIN = 4'd3,
                         RA_MASK = 4'd4, RA_TYPE = 4'd5, RA_EDGE = 4'd6, RA_LVL = 4'd7,
                         RA_PEND = 4'd8;

  always #4 clk = ~clk;

  gpio_irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pin),
    .oe_o(oe), .out_o(outv), .alt_o(alt), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [15:0] d;
    logic [1:0]  sel;
  } vec_t;

  // sel: 0 readback only, 1 oe_o, 2 out_o, 3 alt_o
  localparam vec_t VEC [7] = '{
    '{a: 4'd0, d: 16'h1234, sel: 2'd1},
    '{a: 4'd1, d: 16'hBEEF, sel: 2'd2},
    '{a: 4'd2, d: 16'h0F0F, sel: 2'd3},
    '{a: 4'd4, d: 16'h8001, sel: 2'd0},
    '{a: 4'd5, d: 16'h00F0, sel: 2'd0},
    '{a: 4'd6, d: 16'h5555, sel: 2'd0},
    '{a: 4'd7, d: 16'hA5A5, sel: 2'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin = '0;
    step(4);
    rst_n = 1'b1;
    // R1: checked before the first edge after release
    rchk("R1 pend", RA_PEND, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rchk("R1 mask", RA_MASK, 16'hFFFF);
    step(1);
    rchk("R1 dir", RA_DIR, 16'h0);
    rchk("R1 type", RA_TYPE, 16'h0);
    chk("R1 oe", oe, 16'h0);

    // R3: two-flop synchronizer latency
    pin = 16'h5A3C;
    step(1);
    rchk("R3 early", RA_PIN, 16'h0);
    step(1);
    rchk("R3 status", RA_PIN, 16'h5A3C);
    pin = 16'h0;

    // R2: register vector table
    foreach (VEC[i]) begin
      wr(VEC[i].a, VEC[i].d);
      rchk("R2 readback", VEC[i].a, VEC[i].d);
      case (VEC[i].sel)
        2'd1: chk("R2 oe_o", oe, VEC[i].d);
        2'd2: chk("R2 out_o", outv, VEC[i].d);
        2'd3: chk("R2 alt_o", alt, VEC[i].d);
        default: ;
      endcase
    end

    // quiet configuration: all level-high, all unmasked
    wr(RA_LVL, 16'hFFFF);
    wr(RA_TYPE, 16'h0);
    wr(RA_EDGE, 16'h0);
    wr(RA_MASK, 16'h0);
    step(3);
    wr(RA_PEND, 16'h0);
    rchk("R8 clear", RA_PEND, 16'h0);
    chk("R10 idle irq", {15'h0, irq}, 16'h0);

    // R8: load arbitrary value
    wr(RA_PEND, 16'hF00F);
    rchk("R8 load", RA_PEND, 16'hF00F);
    chk("R10 irq set", {15'h0, irq}, 16'h1);
    wr(RA_PEND, 16'h0);

    // R4: rising edge on pin 0
    wr(RA_TYPE, 16'h0001);
    wr(RA_EDGE, 16'h0001);
    pin[0] = 1'b1;
    step(2);
    rchk("R4 early", RA_PEND, 16'h0);
    step(1);
    rchk("R4 set", RA_PEND, 16'h0001);
    chk("R4 irq", {15'h0, irq}, 16'h1);
    wr(RA_PEND, 16'h0);
    step(3);
    rchk("R4 no retrigger", RA_PEND, 16'h0);

    // R5: falling edge on pin 1
    wr(RA_TYPE, 16'h0003);
    pin[1] = 1'b1;
    step(3);
    rchk("R5 rise ignored", RA_PEND, 16'h0);
    pin[1] = 1'b0;
    step(2);
    rchk("R5 early", RA_PEND, 16'h0);
    step(1);
    rchk("R5 set", RA_PEND, 16'h0002);
    wr(RA_PEND, 16'h0);

    // R6: active-high pin 2, then active-low pin 3
    pin[2] = 1'b1;
    step(3);
    rchk("R6 high", RA_PEND, 16'h0004);
    wr(RA_LVL, 16'hFFF7);
    step(1);
    rchk("R6 low", RA_PEND, 16'h000C);
    wr(RA_LVL, 16'hFFFF);

    // R7: active level survives a clear
    wr(RA_PEND, 16'h0);
    rchk("R7 level reasserts", RA_PEND, 16'h0004);
    pin[2] = 1'b0;
    step(3);
    wr(RA_PEND, 16'h0);
    rchk("R7 cleared", RA_PEND, 16'h0);

    // R9: edge event and clear on the same edge
    wr(RA_TYPE, 16'h0043);
    wr(RA_EDGE, 16'h0041);
    pin[6] = 1'b1;
    step(1);
    step(1);
    wr(RA_PEND, 16'h0);
    rchk("R9 hw wins", RA_PEND, 16'h0040);

    // R10: mask blocks summary but not pending
    wr(RA_MASK, 16'h0040);
    chk("R10 masked irq", {15'h0, irq}, 16'h0);
    rchk("R10 pend kept", RA_PEND, 16'h0040);
    wr(RA_MASK, 16'h0);
    chk("R10 unmasked irq", {15'h0, irq}, 16'h1);
    wr(RA_PEND, 16'h0);
    chk("R10 cleared irq", {15'h0, irq}, 16'h0);

    // R11: edge bit unused in level mode, level bit unused in edge mode
    pin[4] = 1'b1;
    step(3);
    rchk("R11 level ignores edge", RA_PEND, 16'h0010);
    pin[4] = 1'b0;
    step(3);
    wr(RA_PEND, 16'h0);
    wr(RA_TYPE, 16'h0063);
    wr(RA_LVL, 16'hFFDF);
    step(3);
    rchk("R11 edge ignores level", RA_PEND, 16'h0);
    wr(RA_LVL, 16'hFFFF);

    // R12: status read-only, unused address reads zero
    wr(RA_PIN, 16'hFFFF);
    rchk("R12 status ro", RA_PIN, 16'h0041);
    rchk("R12 unused", 4'd15, 16'h0);

    finish_run();
  end
endmodule